// File: doc/BRIEF.md
# Serial Bus Reference Tick Prescaler

This block derives the slow reference tick that paces every bit slot of a single-wire serial bus master from the much faster system clock. Software or a neighbouring control block writes one 8-bit configuration code through a write strobe. The code chooses an odd divide ratio and a power-of-two prescale, and it carries a run/stop bit. The block then sends out a tick that is one system clock wide, once per (odd ratio × 2^n) clocks. Each write restarts both dividers from zero, so the first tick after a change always comes one full new period later and never one from the old setting.

A typical user picks the code so that the tick lands at 1 MHz. Examples are code 0x80 on a 1 MHz clock, 0x84 on 2 MHz, 0x81 on 3 MHz, 0x8C on 8 MHz and 0x9C on 128 MHz. The stored code can be read back at any time, with the two unused bits shown as zero.

Top module: `owm_tick_prescaler`

## Requirements
- R1: After synchronous reset the read-back code is 0x00 and no tick is produced until a code with bit 7 set is written.
- R2: Bit 7 of the code is the run bit. While the stored code has bit 7 at 0, the tick output stays low on every cycle.
- R3: Code bits [1:0] holding value v select an odd divide ratio of 2v+1, giving 1, 3, 5 or 7.
- R4: Code bits [4:2] holding value n select an additional divide by 2^n, for n from 0 to 7.
- R5: With the run bit set, the tick period in system clocks is the product of the R3 and R4 factors. Each tick lasts one cycle, except at period 1, where the tick stays high on every cycle.
- R6: A write restarts counting. The tick is low in the cycle after the write edge, and the first tick is high in the cycle after the P-th rising edge that follows the write edge, where P is the new period.
- R7: Code bits 5 and 6 are reserved. They read back as 0 and have no effect on the tick.
- R8: In the cycle after a write edge, the read-back port shows the written code with bits 5 and 6 cleared.
- R9: Codes 0x80, 0x84, 0x81, 0x8C and 0x9C give periods of 1, 2, 3, 8 and 128 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration code |
| cfg_wdata | input | 8 | Configuration code to be written |
| cfg_rdata | output | 8 | Stored configuration code, reserved bits zero |
| tick_o | output | 1 | Reference tick, one clock wide |

## Verification
The write edge is the timing reference for every result. Read-back is due one cycle after it. The tick is due in the cycle after the P-th edge that follows it, and again after every further P edges. The bench drives each write half a cycle before the edge and counts edges from the write onward. It samples one time unit after each edge and expects a tick exactly when the edge count is a non-zero multiple of P. Every result is therefore compared in the single cycle where the registered tick and code become visible.

// File: rtl/owm_tick_pkg.sv
package owm_tick_pkg;

    localparam int ODD_SEL_W = 2;
    localparam int POW_SEL_W = 3;
    localparam int CODE_W    = 8;
    localparam int RUN_POS   = CODE_W - 1;
    localparam int POW_LSB   = ODD_SEL_W;

    typedef struct packed {
        logic                 run;
        logic [POW_SEL_W-1:0] pow_sel;
        logic [ODD_SEL_W-1:0] odd_sel;
    } tick_cfg_t;

    function automatic tick_cfg_t code_to_cfg(input logic [CODE_W-1:0] code);
        tick_cfg_t c;
        c.run     = code[RUN_POS];
        c.pow_sel = code[POW_LSB +: POW_SEL_W];
        c.odd_sel = code[0 +: ODD_SEL_W];
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] cfg_to_code(input tick_cfg_t c);
        logic [CODE_W-1:0] code;
        code                        = '0;
        code[RUN_POS]               = c.run;
        code[POW_LSB +: POW_SEL_W]  = c.pow_sel;
        code[0 +: ODD_SEL_W]        = c.odd_sel;
        return code;
    endfunction

endpackage

// File: rtl/owm_tick_cfg.sv
module owm_tick_cfg
    import owm_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CODE_W-1:0] wdata,
    output tick_cfg_t         cfg,
    output logic [CODE_W-1:0] rdata
);
    tick_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= code_to_cfg(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_to_code(cfg_q);
endmodule

// File: rtl/owm_odd_div.sv
module owm_odd_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             carry
);
    localparam int CNT_W = SEL_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last  = {sel, 1'b0};
    assign carry = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (carry) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owm_pow2_div.sv
module owm_pow2_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             terminal
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             at_mask;

    assign mask     = {CNT_W{1'b1}} >> (CNT_W - int'(sel));
    assign at_mask  = ((cnt_q & mask) == mask);
    assign terminal = step && at_mask;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (terminal) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owm_tick_prescaler.sv
module owm_tick_prescaler
    import owm_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              tick_o
);
    tick_cfg_t cfg;
    logic      hold;
    logic      odd_carry;
    logic      period_end;
    logic      tick_q;

    owm_tick_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    assign hold = cfg_we || !cfg.run;

    owm_odd_div #(.SEL_W(ODD_SEL_W)) u_odd (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .sel   (cfg.odd_sel),
        .carry (odd_carry)
    );

    owm_pow2_div #(.SEL_W(POW_SEL_W)) u_pow (
        .clk      (clk),
        .rst      (rst),
        .clear    (hold),
        .step     (odd_carry),
        .sel      (cfg.pow_sel),
        .terminal (period_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= !hold && period_end;
        end
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/owm_tick_prescaler_chk.sv
module owm_tick_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       tick_o
);
    logic [10:0] period;
    logic [10:0] since_q;

    assign period = 11'(({8'd0, cfg_rdata[1:0], 1'b0} + 11'd1) << cfg_rdata[4:2]);

    always_ff @(posedge clk) begin
        if (rst || cfg_we) begin
            since_q <= '0;
        end else if (tick_o) begin
            since_q <= 11'd1;
        end else if (since_q != 11'h7FF) begin
            since_q <= since_q + 11'd1;
        end
    end

    assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> cfg_rdata[7]);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6:5] == 2'b00);

    assert_write_silences_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !tick_o);

    assert_readback_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & 8'h9F)));

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_o && period > 11'd1) |=> !tick_o);

    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (since_q == period));
endmodule

bind owm_tick_prescaler owm_tick_prescaler_chk u_chk (.*);

// File: tb/owm_tick_prescaler_tb.sv
module owm_tick_prescaler_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tick_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    owm_tick_prescaler u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick_o    (tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_period(input logic [7:0] code);
        return (2 * int'(code[1:0]) + 1) * (1 << code[4:2]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write lands on the next rising edge; returns 1 time unit after it
    task automatic write_code(input logic [7:0] code);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = code;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // checks ticks over n edges after the write edge, plus read-back
    task automatic run_code(input logic [7:0] code, input int n, input string req);
        int p;
        int miss;
        int first_k;
        int first_a;
        write_code(code);
        check(cfg_rdata == (code & 8'h9F), "R8 readback", int'(cfg_rdata), int'(code & 8'h9F));
        check(tick_o == 1'b0, "R6 no tick after write", int'(tick_o), 0);
        p = exp_period(code);
        miss = 0;
        first_k = -1;
        first_a = 0;
        for (int k = 1; k <= n; k++) begin
            bit e;
            @(posedge clk);
            #1;
            e = code[7] && (k % p == 0);
            if (tick_o !== e) begin
                miss++;
                if (first_k < 0) begin
                    first_k = k;
                    first_a = int'(tick_o);
                end
            end
        end
        if (miss != 0)
            $display("  code %02h: first mismatch at edge %0d, tick=%0d", code, first_k, first_a);
        check(miss == 0, req, miss, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state
        check(cfg_rdata == 8'h00, "R1 reset code", int'(cfg_rdata), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(posedge clk);
                #1;
                if (tick_o) seen++;
            end
            check(seen == 0, "R1 no tick after reset", seen, 0);
        end

        // R3 R4 R5: sweep every odd/power combination with run set
        for (int c = 0; c < 32; c++) begin
            logic [7:0] code;
            code = 8'h80 | 8'(c[4:0]);
            run_code(code, 3 * exp_period(code) + 2, "R3/R4 R5 period sweep");
        end

        // R2: run bit clear, codes across the sweep
        run_code(8'h1F, 200, "R2 stopped no ticks");
        run_code(8'h00, 50, "R2 stopped no ticks");
        run_code(8'h0D, 80, "R2 stopped no ticks");

        // R7: reserved bits ignored and read as zero
        run_code(8'hE1, 20, "R7 reserved bits ignored");
        run_code(8'hA4, 20, "R7 reserved bits ignored");
        run_code(8'h60, 20, "R7 reserved no run effect");

        // R9: named example codes
        check(exp_period(8'h80) == 1, "R9 code 80", exp_period(8'h80), 1);
        run_code(8'h84, 10, "R9 code 84 period 2");
        run_code(8'h81, 12, "R9 code 81 period 3");
        run_code(8'h8C, 30, "R9 code 8C period 8");
        run_code(8'h9C, 300, "R9 code 9C period 128");

        // R6: rewrite mid-period restarts from zero
        write_code(8'h9C);
        repeat (50) @(posedge clk);
        run_code(8'h82, 25, "R6 restart mid period");
        write_code(8'h83);
        repeat (4) @(posedge clk);
        run_code(8'h83, 30, "R6 same code rewrite restarts");
        run_code(8'h05, 30, "R6 stop via write");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule